// File: doc/BRIEF.md
# Command-Decoded SPI Slave with Byte Queues

The block is a mode 0 SPI slave that lets an external host reach a small bank of 16-bit registers and two 32-byte queues. Every chip-select window opens with a command byte. Its top three bits choose one of four operations: register read, register write, queue read or queue write. For register commands, the low five bits carry the register address and a mandatory marker bit. For queue commands, the low five bits carry a byte count.

Bytes the host writes land in the receive queue, and logic on the chip drains that queue through a valid/ready handshake. Logic on the chip fills the transmit queue through a second valid/ready handshake, and the host drains it with queue reads. A status register watches the receive queue level against a programmable threshold. Its bits stay set until the host clears them, and each bit can be routed to an interrupt output. The serial clock is oversampled by the system clock after a synchroniser chain.

Top module: `spi_fifo_slave`

## Requirements
- R1: SPI mode 0 only, 8-bit bytes, MSB first. MOSI is sampled on SCK rising edges and MISO changes after SCK falling edges. MISO is 0 for every bit of the command byte.
- R2: Command bits [7:5] decode as follows: 000 register read, 001 register write, 011 queue read, 101 queue write. Any other opcode is ignored, and so is a register command whose bit 0 is 0. An ignored command returns 0x00 bytes and changes no state.
- R3: After a register read command (bits [4:1] address, bit 0 = 1), the next two bytes return the 16-bit value, high byte first. Any further bytes return 0x00.
- R4: After a register write command, the next two bytes give the value, high byte first. The write takes effect after the second byte. At address 0, bits [11:6] hold the transmit threshold and bits [5:0] hold the receive threshold; bits [15:12] read back as 0. Address 2 holds the interrupt enables, with only bits 4, 2, 1 and 0 writable. Writes to unused addresses have no effect, and those addresses read as 0.
- R5: Address 4 reads the receive queue count in bits [11:6] and the transmit queue count in bits [5:0].
- R6: A queue write command with count field N (bits [4:0]; 0 means 32) pushes up to N following bytes into the receive queue. Bytes beyond N are ignored. A byte that arrives while the queue holds 32 entries is dropped, and the count is unchanged.
- R7: A queue read command with count field N (0 means 32) returns up to N bytes from the transmit queue in push order. A slot taken while the queue is empty returns 0x00 and consumes nothing. Bytes beyond N return 0x00 and consume nothing.
- R8: Address 1 is the status register. Bit 4 means receive count != 0, bit 2 means count > receive threshold, bit 1 means count == 0, and bit 0 means count < receive threshold. Each bit sets while its condition holds and stays set until it is cleared. Bit 3 and bits [15:5] read 0.
- R9: Address 3 reads 0x0000. Writing 1 to one of its bits 4, 2, 1 or 0 clears that status bit, unless the condition still holds, in which case the bit sets again.
- R10: The irq output is high while any status bit is set and also enabled, and low otherwise.
- R11: Raising chip select aborts the transaction in progress. A register write with fewer than two value bytes is not applied. The next chip-select fall starts a new command.
- R12: The transmit queue accepts a push from the chip side when tx_push_ready is high, which it is whenever the queue holds fewer than 32 bytes. The receive queue presents its oldest byte with rx_pop_valid while it is non-empty, and removes that byte on rx_pop_ready.
- R13: After reset, both queues are empty, thresholds and enables are 0, irq is low and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Host-to-slave data |
| spi_miso | output | 1 | Slave-to-host data |
| irq | output | 1 | Interrupt: some status bit is both set and enabled |
| tx_push_valid | input | 1 | Chip side offers a byte for the transmit queue |
| tx_push_data | input | 8 | Byte for the transmit queue |
| tx_push_ready | output | 1 | Transmit queue has room |
| rx_pop_valid | output | 1 | Receive queue holds a byte |
| rx_pop_data | output | 8 | Oldest byte in the receive queue |
| rx_pop_ready | input | 1 | Chip side takes the presented byte |

## Verification
A received byte reaches the receive queue and the register bank about four system clocks after its eighth SCK rise: two synchroniser stages, an edge detector and a write pulse. A status bit follows one clock later, and irq one clock after that. An outgoing byte reaches MISO about four clocks after the SCK fall that starts its slot. The bench holds each SCK phase for 13 clocks and samples MISO just before each rise, so every serial result has settled. Register values, queue counts and irq are read only after chip select has been high for 13 clocks, which is well past the longest internal chain.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam logic [2:0] OPC_RREG  = 3'b000;
  localparam logic [2:0] OPC_WREG  = 3'b001;
  localparam logic [2:0] OPC_RFIFO = 3'b011;
  localparam logic [2:0] OPC_WFIFO = 3'b101;

  localparam logic [3:0] RA_THRESH = 4'd0;
  localparam logic [3:0] RA_STATUS = 4'd1;
  localparam logic [3:0] RA_ENABLE = 4'd2;
  localparam logic [3:0] RA_CLEAR  = 4'd3;
  localparam logic [3:0] RA_LEVELS = 4'd4;

  localparam int SB_UNDER    = 0;
  localparam int SB_EMPTY    = 1;
  localparam int SB_OVER     = 2;
  localparam int SB_NONEMPTY = 4;
  localparam logic [4:0] STAT_MASK = 5'b10111;

  localparam int FW = 6;   // width of one level/threshold field
  localparam int RW = 12;  // writable register bits

  typedef enum logic [2:0] {OP_IDLE, OP_RREG, OP_WREG, OP_RFIFO, OP_WFIFO} spi_op_e;
endpackage

// File: rtl/spi_fifo_sync.sv
module spi_fifo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_active,
  output logic mosi_s
);
  logic [STAGES-1:0] sck_p, cs_p, mosi_p;
  logic sck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p    <= '0;
      cs_p     <= '1;
      mosi_p   <= '0;
      sck_last <= 1'b0;
    end else begin
      sck_p    <= {sck_p[STAGES-2:0], sck_i};
      cs_p     <= {cs_p[STAGES-2:0], cs_n_i};
      mosi_p   <= {mosi_p[STAGES-2:0], mosi_i};
      sck_last <= sck_p[STAGES-1];
    end
  end

  assign cs_active = ~cs_p[STAGES-1];
  assign mosi_s    = mosi_p[STAGES-1];
  assign sck_rise  = cs_active & sck_p[STAGES-1] & ~sck_last;
  assign sck_fall  = cs_active & ~sck_p[STAGES-1] & sck_last;
endmodule

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int DW = 8,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] wp, rp;
  logic do_push, do_pop;

  assign count   = wp - rp;
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_count_step_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1 ||
              count == $past(count) - 1'b1));
endmodule

// File: rtl/spi_fifo_regs.sv
module spi_fifo_regs
  import spi_fifo_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [3:0]    addr,
  input  logic [RW-1:0] wdata,
  input  logic [FW-1:0] rx_cnt,
  input  logic [FW-1:0] tx_cnt,
  output logic [15:0]   rdata,
  output logic          irq
);
  logic [FW-1:0] thr_tx, thr_rx;
  logic [4:0] en, status, cond, clr;

  always_comb begin
    cond = '0;
    cond[SB_NONEMPTY] = (rx_cnt != '0);
    cond[SB_OVER]     = (rx_cnt > thr_rx);
    cond[SB_EMPTY]    = (rx_cnt == '0);
    cond[SB_UNDER]    = (rx_cnt < thr_rx);
    clr = (we && addr == RA_CLEAR) ? wdata[4:0] : 5'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_tx <= '0;
      thr_rx <= '0;
      en     <= '0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      if (we && addr == RA_THRESH) begin
        thr_tx <= wdata[2*FW-1:FW];
        thr_rx <= wdata[FW-1:0];
      end
      if (we && addr == RA_ENABLE) en <= wdata[4:0] & STAT_MASK;
      status <= (cond | (status & ~clr)) & STAT_MASK;
      irq    <= |(status & en);
    end
  end

  always_comb begin
    case (addr)
      RA_THRESH: rdata = {4'b0, thr_tx, thr_rx};
      RA_STATUS: rdata = {11'b0, status};
      RA_ENABLE: rdata = {11'b0, en};
      RA_LEVELS: rdata = {4'b0, rx_cnt, tx_cnt};
      default:   rdata = 16'h0000;
    endcase
  end

  assert_empty_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt == '0) |=> status[SB_EMPTY]);
  assert_nonempty_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt != '0) |=> status[SB_NONEMPTY]);
  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (we && addr == RA_CLEAR && wdata[SB_NONEMPTY] && rx_cnt == '0) |=> !status[SB_NONEMPTY]);
  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq);
endmodule

// File: rtl/spi_fifo_slave.sv
module spi_fifo_slave
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       irq,
  input  logic       tx_push_valid,
  input  logic [7:0] tx_push_data,
  output logic       tx_push_ready,
  output logic       rx_pop_valid,
  output logic [7:0] rx_pop_data,
  input  logic       rx_pop_ready
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic sck_rise, sck_fall, cs_active, mosi_s;
  logic [2:0] bit_cnt;
  logic [5:0] byte_idx, xfer_len;
  logic [7:0] in_sh, out_sh, rd_lo;
  logic [3:0] wr_hi, reg_addr;
  spi_op_e op;
  logic reg_we, rx_push;
  logic [RW-1:0] reg_wdata;
  logic [7:0] rx_din, tx_dout;
  logic tx_pop, tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [15:0] reg_rdata;
  logic [7:0] in_byte;
  logic byte_done, load_slot, in_window;

  spi_fifo_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck_i(spi_sck), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_active(cs_active), .mosi_s(mosi_s));

  assign in_byte   = {in_sh[6:0], mosi_s};
  assign byte_done = sck_rise && bit_cnt == 3'd7;
  assign load_slot = sck_fall && bit_cnt == 3'd0 && byte_idx != '0;
  assign in_window = byte_idx != '0 && byte_idx <= xfer_len;
  assign tx_pop    = load_slot && op == OP_RFIFO && in_window && !tx_empty;
  assign spi_miso  = out_sh[7];

  always_ff @(posedge clk) begin
    if (rst || !cs_active) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      in_sh    <= '0;
      out_sh   <= '0;
      op       <= OP_IDLE;
      xfer_len <= '0;
      reg_addr <= '0;
      wr_hi    <= '0;
      rd_lo    <= '0;
    end else begin
      if (sck_rise) begin
        in_sh   <= in_byte;
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done) begin
        if (byte_idx != '1) byte_idx <= byte_idx + 6'd1;
        if (byte_idx == '0) begin
          reg_addr <= in_byte[4:1];
          xfer_len <= (in_byte[4:0] == '0) ? 6'd32 : {1'b0, in_byte[4:0]};
          case (in_byte[7:5])
            OPC_RREG:  op <= in_byte[0] ? OP_RREG : OP_IDLE;
            OPC_WREG:  op <= in_byte[0] ? OP_WREG : OP_IDLE;
            OPC_RFIFO: op <= OP_RFIFO;
            OPC_WFIFO: op <= OP_WFIFO;
            default:   op <= OP_IDLE;
          endcase
        end else if (op == OP_WREG && byte_idx == 6'd1) begin
          wr_hi <= in_byte[3:0];
        end
      end
      if (sck_fall) begin
        if (load_slot) begin
          case (op)
            OP_RREG: begin
              if (byte_idx == 6'd1) begin
                out_sh <= reg_rdata[15:8];
                rd_lo  <= reg_rdata[7:0];
              end else if (byte_idx == 6'd2) out_sh <= rd_lo;
              else out_sh <= '0;
            end
            OP_RFIFO: out_sh <= tx_pop ? tx_dout : 8'h00;
            default:  out_sh <= '0;
          endcase
        end else begin
          out_sh <= {out_sh[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_we    <= 1'b0;
      rx_push   <= 1'b0;
      reg_wdata <= '0;
      rx_din    <= '0;
    end else begin
      reg_we    <= byte_done && op == OP_WREG && byte_idx == 6'd2;
      reg_wdata <= {wr_hi, in_byte};
      rx_push   <= byte_done && op == OP_WFIFO && in_window;
      rx_din    <= in_byte;
    end
  end

  spi_fifo_buf #(.DW(8), .DEPTH(DEPTH)) u_rx_q (
    .clk(clk), .rst(rst), .push(rx_push && !rx_full), .din(rx_din),
    .pop(rx_pop_ready), .dout(rx_pop_data), .full(rx_full), .empty(rx_empty),
    .count(rx_cnt));

  spi_fifo_buf #(.DW(8), .DEPTH(DEPTH)) u_tx_q (
    .clk(clk), .rst(rst), .push(tx_push_valid), .din(tx_push_data),
    .pop(tx_pop), .dout(tx_dout), .full(tx_full), .empty(tx_empty),
    .count(tx_cnt));

  assign tx_push_ready = ~tx_full;
  assign rx_pop_valid  = ~rx_empty;

  spi_fifo_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rx_cnt(FW'(rx_cnt)), .tx_cnt(FW'(tx_cnt)), .rdata(reg_rdata), .irq(irq));

  assert_cmd_byte_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (cs_active && byte_idx == '0) |-> !spi_miso);
  assert_abort_clears_R11: assert property (@(posedge clk) disable iff (rst)
    !cs_active |=> (byte_idx == '0 && op == OP_IDLE && !spi_miso));
  assert_pop_only_reads_R7: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> (cs_active && !tx_empty));
endmodule

// File: tb/test_spi_fifo_slave.sv
module test_spi_fifo_slave;
  localparam int HALF = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, irq, tx_push_ready, rx_pop_valid;
  logic tx_push_valid = 1'b0, rx_pop_ready = 1'b0;
  logic [7:0] tx_push_data = 8'h00;
  logic [7:0] rx_pop_data;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_fifo_slave i_spi_fifo_slave (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .irq(irq), .tx_push_valid(tx_push_valid),
    .tx_push_data(tx_push_data), .tx_push_ready(tx_push_ready),
    .rx_pop_valid(rx_pop_valid), .rx_pop_data(rx_pop_data), .rx_pop_ready(rx_pop_ready));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nb; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic cs_open();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_close();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] c);
    logic [7:0] r;
    xb(c, r);
    check("R1", r, 0, "command byte reply");
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] hi, lo, ex;
    cs_open();
    cmd({3'b000, a, 1'b1});
    xb(8'h00, hi);
    xb(8'h00, lo);
    xb(8'h00, ex);
    check("R3", ex, 0, "byte after register value");
    cs_close();
    v = {hi, lo};
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [15:0] exp, input string req);
    logic [15:0] v;
    reg_read(a, v);
    check(req, v, exp, $sformatf("register %0d", a));
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [15:0] v);
    logic [7:0] r;
    cs_open();
    cmd({3'b001, a, 1'b1});
    xb(v[15:8], r);
    xb(v[7:0], r);
    cs_close();
  endtask

  task automatic q_write(input logic [4:0] n, input int nbytes, input logic [7:0] base);
    logic [7:0] r;
    cs_open();
    cmd({3'b101, n});
    for (int i = 0; i < nbytes; i++) xb(8'(base + i), r);
    cs_close();
  endtask

  task automatic q_read(input logic [4:0] n, input int nbytes, input logic [7:0] base,
                        input int avail);
    logic [7:0] r;
    int len;
    len = (n == 0) ? 32 : int'(n);
    cs_open();
    cmd({3'b011, n});
    for (int i = 0; i < nbytes; i++) begin
      xb(8'h00, r);
      check("R7", r, (i < len && i < avail) ? 8'(base + i) : 8'h00, $sformatf("read slot %0d", i));
    end
    cs_close();
  endtask

  task automatic push_tx(input logic [7:0] d, input logic exp_ready);
    @(negedge clk);
    check("R12", tx_push_ready, exp_ready, "tx_push_ready");
    tx_push_valid = 1'b1;
    tx_push_data = d;
    @(negedge clk);
    tx_push_valid = 1'b0;
  endtask

  task automatic pop_rx(input logic [7:0] exp);
    @(negedge clk);
    check("R12", rx_pop_valid, 1, "rx_pop_valid");
    check("R6", rx_pop_data, exp, "received byte");
    rx_pop_ready = 1'b1;
    @(negedge clk);
    rx_pop_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int len;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R13 reset state
    check("R13", spi_miso, 0, "miso after reset");
    check("R13", irq, 0, "irq after reset");
    check("R13", tx_push_ready, 1, "tx ready after reset");
    check("R13", rx_pop_valid, 0, "rx valid after reset");
    rd_check(4'd4, 16'h0000, "R5");
    rd_check(4'd0, 16'h0000, "R13");
    rd_check(4'd1, 16'h0002, "R8");

    // R4 thresholds: tx 5, rx 3, top nibble dropped
    reg_write(4'd0, 16'hF143);
    rd_check(4'd0, 16'h0143, "R4");
    rd_check(4'd1, 16'h0003, "R8");
    rd_check(4'd3, 16'h0000, "R9");
    reg_write(4'd7, 16'h1234);
    rd_check(4'd7, 16'h0000, "R4");
    reg_write(4'd2, 16'hFFFF);
    rd_check(4'd2, 16'h0017, "R4");
    check("R10", irq, 1, "irq with enables on");
    reg_write(4'd2, 16'h0000);
    check("R10", irq, 0, "irq with enables off");

    // R2 ignored opcodes and marker bit 0
    foreach (r[k]) ;
    for (int opc = 2; opc < 8; opc++) begin
      if (opc == 3 || opc == 5) continue;
      cs_open();
      cmd({3'(opc), 5'h1F});
      xb(8'hA5, r);
      check("R2", r, 0, "reply after ignored opcode");
      xb(8'h5A, r);
      cs_close();
    end
    rd_check(4'd4, 16'h0000, "R2");
    cs_open();
    cmd(8'h20);
    xb(8'h00, r);
    xb(8'h00, r);
    cs_close();
    rd_check(4'd0, 16'h0143, "R2");
    cs_open();
    cmd(8'h08);
    xb(8'h00, r);
    check("R2", r, 0, "read with marker bit 0");
    cs_close();

    // R6 queue write sweep with trailing extra bytes
    for (int n = 1; n <= 5; n += 2) begin
      len = n;
      q_write(5'(n), len + 2, 8'(n * 40 + 3));
      rd_check(4'd4, 16'(len << 6), "R6");
      for (int i = 0; i < len; i++) pop_rx(8'(n * 40 + 3 + i));
      rd_check(4'd4, 16'h0000, "R12");
    end

    // R6 fill with N=0, then overflow attempt
    q_write(5'd0, 33, 8'h10);
    rd_check(4'd4, 16'h0800, "R6");
    q_write(5'd3, 3, 8'hEE);
    rd_check(4'd4, 16'h0800, "R6");
    rd_check(4'd1, 16'h0017, "R8");
    reg_write(4'd3, 16'h0017);
    rd_check(4'd1, 16'h0014, "R9");
    reg_write(4'd2, 16'h0004);
    check("R10", irq, 1, "irq on over-threshold");
    for (int i = 0; i < 32; i++) pop_rx(8'(8'h10 + i));
    rd_check(4'd1, 16'h0017, "R8");
    check("R10", irq, 1, "irq held by sticky bit");
    reg_write(4'd3, 16'h0004);
    rd_check(4'd1, 16'h0013, "R9");
    check("R10", irq, 0, "irq after clear");

    // R7 transmit queue reads
    for (int i = 0; i < 3; i++) push_tx(8'(8'h11 + i), 1'b1);
    rd_check(4'd4, 16'h0003, "R5");
    q_read(5'd5, 6, 8'h11, 3);
    rd_check(4'd4, 16'h0000, "R7");
    for (int i = 0; i < 4; i++) push_tx(8'(8'h41 + i), 1'b1);
    q_read(5'd2, 3, 8'h41, 4);
    rd_check(4'd4, 16'h0002, "R7");
    q_read(5'd2, 2, 8'h43, 2);
    for (int i = 0; i < 33; i++) push_tx(8'(8'h80 + i), i < 32);
    rd_check(4'd4, 16'h0020, "R12");
    q_read(5'd0, 32, 8'h80, 32);
    rd_check(4'd4, 16'h0000, "R7");

    // R11 aborts
    cs_open();
    cmd(8'h21);
    xb(8'h0F, r);
    cs_close();
    rd_check(4'd0, 16'h0143, "R11");
    cs_open();
    spi_bits(8'hFF, 4, r);
    cs_close();
    reg_write(4'd0, 16'h0ABC);
    rd_check(4'd0, 16'h0ABC, "R11");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule